// File: doc/BRIEF.md
# Status Flag and Conditional Branch Unit

This block owns the processor's eight-bit status register and the instructions that act on single flags. It decodes the current instruction word and carries out explicit flag set and flag clear operations. It resolves branch-on-flag instructions into a taken indication and the address of the next fetch. It moves single bits between a register operand and the transfer flag (T). It also evaluates skip-on-register-bit instructions, so that the fetch stage can discard the following instruction.

Flag updates from the arithmetic unit arrive as per-bit write strobes with values, and they are merged into the status register on the same clock edge as any explicit flag write. The branch, skip and bit-load results are combinational in the current instruction. They use the status register as it stood before the current edge. The status register itself changes on the rising clock edge.

The program-counter register, the register file and the arithmetic unit sit outside this block. The block receives the current program counter and the selected register byte. It returns the next program counter and, for a bit-load, the byte to write back.

Top module: `flag_branch_unit`

## Requirements
- R1: The asynchronous active-low reset `rstN` clears every status bit, so `sreg` reads 8'h00 while reset is held and right after it is released.
- R2: The status bits sit in this fixed order: C=bit 0, Z=bit 1, N=bit 2, V=bit 3, S=bit 4, H=bit 5, T=bit 6, I=bit 7. A flag index f always refers to `sreg[f]`.
- R3: The instruction 16'b1001_0100_0fff_1000 (set flag) sets `sreg[fff]` at the next rising edge.
- R4: The instruction 16'b1001_0100_1fff_1000 (clear flag) clears `sreg[fff]` at the next rising edge.
- R5: On every rising edge, each bit with `aluFlagWe[i]`=1 takes `aluFlagVal[i]` and each bit without a strobe keeps its value. An explicit set, clear or bit-store on the same edge overrides the strobe for its own bit only.
- R6: The conditional branch 16'b1111_0pkk_kkkk_kfff asserts `branchTaken` when `sreg[fff]` differs from p. So p=0 branches on a set flag and p=1 branches on a clear flag.
- R7: For a taken branch, `nextPc` = `pc` + 1 + k, where k = instr[9:3] is a signed 7-bit word offset and the sum wraps modulo 2^PC_W. In every other case `nextPc` = `pc` + 1.
- R8: The bit-store instruction 16'b1111_101d_dddd_0bbb copies `regByte[bbb]` into T (bit 6) at the next rising edge.
- R9: The bit-load instruction 16'b1111_100d_dddd_0bbb asserts `regWrEn` with `regWrAddr`=ddddd. `regWrData` is `regByte` with bit bbb replaced by the current T.
- R10: The skip instruction 16'b1111_11xr_rrrr_0bbb asserts `skipNext` when `regByte[bbb]` equals x. So x=0 skips on a clear bit and x=1 skips on a set bit.
- R11: While `instrValid` is 0, the instruction word has no effect: no explicit flag change, `branchTaken`, `skipNext` and `regWrEn` stay 0, and `nextPc` is `pc` + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | Qualifies `instr` for the current cycle |
| instr | input | 16 | Instruction word under execution |
| pc | input | PC_W | Word address of the current instruction |
| aluFlagWe | input | 8 | Per-flag update strobes from the arithmetic unit |
| aluFlagVal | input | 8 | Flag values matching `aluFlagWe` |
| regByte | input | 8 | Register operand named by the instruction |
| sreg | output | 8 | Status register |
| branchTaken | output | 1 | Conditional branch resolved as taken |
| nextPc | output | PC_W | Address of the next fetch |
| skipNext | output | 1 | Discard the next fetched instruction |
| regWrEn | output | 1 | Bit-load write-back request |
| regWrAddr | output | 5 | Destination register of the bit-load |
| regWrData | output | 8 | Byte to write back for the bit-load |

## Verification
The bench targets same-edge collisions between arithmetic strobes and explicit writes to the same flag and to neighbouring flags. A wrong priority there would drop a set or a clear, or would discard an unrelated strobed bit. It drives the extreme offsets +63 and -64 and a wrap past the top of the address space. A design that zero-extends the offset or truncates the sum would jump forward instead of back, or would land on the wrong word. It walks all eight flag indices with both branch polarities, so that a swapped polarity or a mis-sliced flag field shows up as a wrong taken bit. It also shows that an invalid cycle leaves the flags, the skip and the write-back untouched.

// File: rtl/sfbu_pkg.sv
package sfbu_pkg;
  localparam int FLAG_W   = 8;
  localparam int FIDX_W   = $clog2(FLAG_W);
  localparam int DATA_W   = 8;
  localparam int BIDX_W   = $clog2(DATA_W);
  localparam int OFS_W    = 7;
  localparam int RADDR_W  = 5;
  localparam int INSTR_W  = 16;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_H = 5;
  localparam int FLAG_T = 6;
  localparam int FLAG_I = 7;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_FLAGSET,
    OP_FLAGCLR,
    OP_BRANCH,
    OP_BITSTORE,
    OP_BITLOAD,
    OP_SKIP
  } opclass_t;

  typedef struct packed {
    logic               setEn;
    logic               clrEn;
    logic               bstEn;
    logic               bldEn;
    logic               skipEn;
    logic               skipPol;
    logic               brEn;
    logic               brPol;
    logic [FIDX_W-1:0]  flagSel;
    logic [BIDX_W-1:0]  bitSel;
    logic [OFS_W-1:0]   brOfs;
    logic [RADDR_W-1:0] regAddr;
  } ctrl_t;
endpackage

// File: rtl/sfbu_ctrl.sv
module sfbu_ctrl
  import sfbu_pkg::*;
(
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);
  opclass_t opClass;

  always_comb begin
    opClass = OP_NONE;
    if (instrValid) begin
      if (instr[15:8] == 8'h94 && instr[3:0] == 4'h8)
        opClass = instr[7] ? OP_FLAGCLR : OP_FLAGSET;
      else if (instr[15:11] == 5'b11110)
        opClass = OP_BRANCH;
      else if (instr[15:10] == 6'b111111 && !instr[3])
        opClass = OP_SKIP;
      else if (instr[15:9] == 7'b1111101 && !instr[3])
        opClass = OP_BITSTORE;
      else if (instr[15:9] == 7'b1111100 && !instr[3])
        opClass = OP_BITLOAD;
    end
  end

  always_comb begin
    ctrl         = '0;
    ctrl.setEn   = (opClass == OP_FLAGSET);
    ctrl.clrEn   = (opClass == OP_FLAGCLR);
    ctrl.bstEn   = (opClass == OP_BITSTORE);
    ctrl.bldEn   = (opClass == OP_BITLOAD);
    ctrl.skipEn  = (opClass == OP_SKIP);
    ctrl.brEn    = (opClass == OP_BRANCH);
    ctrl.skipPol = instr[9];
    ctrl.brPol   = instr[10];
    ctrl.flagSel = (opClass == OP_FLAGSET || opClass == OP_FLAGCLR)
                   ? instr[6:4] : instr[2:0];
    ctrl.bitSel  = instr[2:0];
    ctrl.brOfs   = instr[9:3];
    ctrl.regAddr = instr[8:4];
  end
endmodule

// File: rtl/sfbu_datapath.sv
module sfbu_datapath
  import sfbu_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [FLAG_W-1:0]  aluFlagWe,
  input  logic [FLAG_W-1:0]  aluFlagVal,
  input  logic [DATA_W-1:0]  regByte,
  input  logic [PC_W-1:0]    pc,
  output logic [FLAG_W-1:0]  sreg,
  output logic               branchTaken,
  output logic [PC_W-1:0]    nextPc,
  output logic               skipNext,
  output logic               regWrEn,
  output logic [RADDR_W-1:0] regWrAddr,
  output logic [DATA_W-1:0]  regWrData
);
  logic [FLAG_W-1:0] sregQ;
  logic [FLAG_W-1:0] sregD;
  logic [FLAG_W-1:0] hitExplicit;
  logic [FLAG_W-1:0] valExplicit;
  logic              selRegBit;

  assign selRegBit = regByte[ctrl.bitSel];

  // Per-flag next-state: explicit instruction first, then arithmetic strobe
  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    logic hitSetClr;
    logic hitStore;
    assign hitSetClr      = (ctrl.setEn || ctrl.clrEn) && (ctrl.flagSel == FIDX_W'(i));
    if (i == FLAG_T) begin : g_tbit
      assign hitStore = ctrl.bstEn;
    end else begin : g_other
      assign hitStore = 1'b0;
    end
    assign hitExplicit[i] = hitSetClr || hitStore;
    assign valExplicit[i] = hitSetClr ? ctrl.setEn : selRegBit;
    assign sregD[i]       = hitExplicit[i] ? valExplicit[i]
                          : aluFlagWe[i]   ? aluFlagVal[i]
                          : sregQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sregQ <= '0;
    else       sregQ <= sregD;
  end

  assign sreg = sregQ;

  // Branch resolution and target arithmetic
  logic [PC_W-1:0] pcInc;
  logic [PC_W-1:0] ofsExt;
  logic [PC_W-1:0] brTarget;
  logic            condBit;

  assign condBit     = sregQ[ctrl.flagSel];
  assign branchTaken = ctrl.brEn && (condBit != ctrl.brPol);
  assign pcInc       = pc + PC_W'(1);
  assign ofsExt      = PC_W'($signed(ctrl.brOfs));
  assign brTarget    = pcInc + ofsExt;
  assign nextPc      = branchTaken ? brTarget : pcInc;

  // Skip on register bit
  assign skipNext = ctrl.skipEn && (selRegBit == ctrl.skipPol);

  // Bit-load: T into the selected register bit
  always_comb begin
    regWrData                = regByte;
    regWrData[ctrl.bitSel]   = sregQ[FLAG_T];
  end
  assign regWrEn   = ctrl.bldEn;
  assign regWrAddr = ctrl.regAddr;
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import sfbu_pkg::*;
#(
  parameter int PC_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [15:0]        instr,
  input  logic [PC_W-1:0]    pc,
  input  logic [7:0]         aluFlagWe,
  input  logic [7:0]         aluFlagVal,
  input  logic [7:0]         regByte,
  output logic [7:0]         sreg,
  output logic               branchTaken,
  output logic [PC_W-1:0]    nextPc,
  output logic               skipNext,
  output logic               regWrEn,
  output logic [4:0]         regWrAddr,
  output logic [7:0]         regWrData
);
  ctrl_t ctrl;

  sfbu_ctrl u_ctrl (
    .instrValid (instrValid),
    .instr      (instr),
    .ctrl       (ctrl)
  );

  sfbu_datapath #(.PC_W(PC_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .aluFlagWe   (aluFlagWe),
    .aluFlagVal  (aluFlagVal),
    .regByte     (regByte),
    .pc          (pc),
    .sreg        (sreg),
    .branchTaken (branchTaken),
    .nextPc      (nextPc),
    .skipNext    (skipNext),
    .regWrEn     (regWrEn),
    .regWrAddr   (regWrAddr),
    .regWrData   (regWrData)
  );
endmodule

// File: rtl/flag_branch_unit_chk.sv
module flag_branch_unit_chk #(
  parameter int PC_W = 14
) (
  input logic            clk,
  input logic            rstN,
  input logic            instrValid,
  input logic [15:0]     instr,
  input logic [PC_W-1:0] pc,
  input logic [7:0]      aluFlagWe,
  input logic [7:0]      aluFlagVal,
  input logic [7:0]      regByte,
  input logic [7:0]      sreg,
  input logic            branchTaken,
  input logic [PC_W-1:0] nextPc,
  input logic            skipNext,
  input logic            regWrEn,
  input logic [4:0]      regWrAddr,
  input logic [7:0]      regWrData
);
  logic rstSeen;
  always_ff @(posedge clk) rstSeen <= !rstN;

  logic isSetOp, isClrOp, isBrOp, isSkipOp, isBstOp, isBldOp;
  assign isSetOp  = instrValid && instr[15:7] == 9'b1001_0100_0 && instr[3:0] == 4'h8;
  assign isClrOp  = instrValid && instr[15:7] == 9'b1001_0100_1 && instr[3:0] == 4'h8;
  assign isBrOp   = instrValid && instr[15:11] == 5'b11110;
  assign isSkipOp = instrValid && instr[15:10] == 6'b111111 && !instr[3];
  assign isBstOp  = instrValid && instr[15:9] == 7'b1111101 && !instr[3];
  assign isBldOp  = instrValid && instr[15:9] == 7'b1111100 && !instr[3];

  always @(posedge clk) begin
    if (!rstN && rstSeen)
      AST_RESET_CLEAR: assert (sreg == 8'h00) else $error("reset did not clear flags"); // R1
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    isSetOp |=> sreg[$past(instr[6:4])] == 1'b1); // R3

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    isClrOp |=> sreg[$past(instr[6:4])] == 1'b0); // R4

  AST_ALU_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> sreg == $past((sreg & ~aluFlagWe) | (aluFlagVal & aluFlagWe))); // R5

  AST_BRANCH_COND: assert property (@(posedge clk) disable iff (!rstN)
    isBrOp |-> branchTaken == (sreg[instr[2:0]] != instr[10])); // R6

  AST_UNTAKEN_PC: assert property (@(posedge clk) disable iff (!rstN)
    !branchTaken |-> nextPc == PC_W'(pc + PC_W'(1))); // R7

  AST_BIT_STORE: assert property (@(posedge clk) disable iff (!rstN)
    isBstOp |=> sreg[6] == $past(regByte[instr[2:0]])); // R8

  AST_BIT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    isBldOp |-> regWrEn && regWrAddr == instr[8:4] && regWrData[instr[2:0]] == sreg[6]); // R9

  AST_SKIP_COND: assert property (@(posedge clk) disable iff (!rstN)
    isSkipOp |-> skipNext == (regByte[instr[2:0]] == instr[9])); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |-> !branchTaken && !skipNext && !regWrEn); // R11
endmodule

bind flag_branch_unit flag_branch_unit_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr), .pc(pc),
  .aluFlagWe(aluFlagWe), .aluFlagVal(aluFlagVal), .regByte(regByte),
  .sreg(sreg), .branchTaken(branchTaken), .nextPc(nextPc), .skipNext(skipNext),
  .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData)
);

// File: tb/flag_branch_unit_bench.sv
module flag_branch_unit_bench;
  localparam int PC_W       = 14;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instrValid = 1'b0;
  logic [15:0]     instr = '0;
  logic [PC_W-1:0] pc = '0;
  logic [7:0]      aluFlagWe = '0;
  logic [7:0]      aluFlagVal = '0;
  logic [7:0]      regByte = '0;
  logic [7:0]      sreg;
  logic            branchTaken;
  logic [PC_W-1:0] nextPc;
  logic            skipNext;
  logic            regWrEn;
  logic [4:0]      regWrAddr;
  logic [7:0]      regWrData;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mdlSreg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_branch_unit #(.PC_W(PC_W)) u_flag_branch_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr), .pc(pc),
    .aluFlagWe(aluFlagWe), .aluFlagVal(aluFlagVal), .regByte(regByte),
    .sreg(sreg), .branchTaken(branchTaken), .nextPc(nextPc), .skipNext(skipNext),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData)
  );

  typedef struct {
    string           req;
    logic            taken;
    logic [PC_W-1:0] npc;
    logic            skip;
    logic            we;
    logic [4:0]      waddr;
    logic [7:0]      wdata;
    logic [7:0]      sregNext;
  } item_t;

  item_t expQ[$];

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fSet(input int f);
    return {9'b1001_0100_0, 3'(f), 4'b1000};
  endfunction
  function automatic logic [15:0] fClr(input int f);
    return {9'b1001_0100_1, 3'(f), 4'b1000};
  endfunction
  function automatic logic [15:0] fBr(input logic p, input int k, input int f);
    return {5'b11110, p, 7'(k), 3'(f)};
  endfunction
  function automatic logic [15:0] fBst(input int d, input int b);
    return {7'b1111101, 5'(d), 1'b0, 3'(b)};
  endfunction
  function automatic logic [15:0] fBld(input int d, input int b);
    return {7'b1111100, 5'(d), 1'b0, 3'(b)};
  endfunction
  function automatic logic [15:0] fSkp(input logic x, input int r, input int b);
    return {6'b111111, x, 5'(r), 1'b0, 3'(b)};
  endfunction

  // Driver: applies one instruction cycle and pushes the expected results
  task automatic step(input logic v, input logic [15:0] ins, input logic [7:0] we,
                      input logic [7:0] val, input logic [7:0] rb,
                      input logic [PC_W-1:0] p, input string req);
    item_t it;
    logic isSC, isBr, isBst, isBld, isSkp;
    @(negedge clk);
    instrValid = v; instr = ins; aluFlagWe = we; aluFlagVal = val;
    regByte = rb; pc = p;
    isSC  = v && ins[15:8] == 8'h94 && ins[3:0] == 4'h8;
    isBr  = v && ins[15:11] == 5'b11110;
    isBst = v && ins[15:9] == 7'b1111101 && !ins[3];
    isBld = v && ins[15:9] == 7'b1111100 && !ins[3];
    isSkp = v && ins[15:10] == 6'b111111 && !ins[3];
    it.req      = req;
    it.sregNext = (mdlSreg & ~we) | (val & we);
    if (isSC)  it.sregNext[ins[6:4]] = !ins[7];
    if (isBst) it.sregNext[6] = rb[ins[2:0]];
    it.taken = isBr && (mdlSreg[ins[2:0]] != ins[10]);
    it.npc   = it.taken ? PC_W'(int'(p) + 1 + int'($signed(ins[9:3])))
                        : PC_W'(int'(p) + 1);
    it.skip  = isSkp && (rb[ins[2:0]] == ins[9]);
    it.we    = isBld;
    it.waddr = ins[8:4];
    it.wdata = rb;
    it.wdata[ins[2:0]] = mdlSreg[6];
    expQ.push_back(it);
    mdlSreg = it.sregNext;
  endtask

  // Monitor: combinational results mid-cycle, flags after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        checkVal(it.req, "branchTaken", 32'(branchTaken), 32'(it.taken));
        checkVal(it.req, "nextPc", 32'(nextPc), 32'(it.npc));
        checkVal(it.req, "skipNext", 32'(skipNext), 32'(it.skip));
        checkVal(it.req, "regWrEn", 32'(regWrEn), 32'(it.we));
        if (it.we) begin
          checkVal(it.req, "regWrAddr", 32'(regWrAddr), 32'(it.waddr));
          checkVal(it.req, "regWrData", 32'(regWrData), 32'(it.wdata));
        end
        @(posedge clk);
        #(CLK_PERIOD/4);
        checkVal(it.req, "sreg", 32'(sreg), 32'(it.sregNext));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R1", "sreg in reset", 32'(sreg), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    #1 checkVal("R1", "sreg after release", 32'(sreg), 32'h0);

    // R3 / R2: set each flag in turn, bit position by index
    for (int f = 0; f < 8; f++) step(1'b1, fSet(f), 8'h00, 8'h00, 8'h00, 14'h0100, "R3");
    // R4: clear flags one at a time
    for (int f = 7; f >= 0; f--) step(1'b1, fClr(f), 8'h00, 8'h00, 8'h00, 14'h0100, "R4");
    step(1'b1, fSet(7), 8'h00, 8'h00, 8'h00, 14'h0000, "R2");
    step(1'b1, fSet(0), 8'h00, 8'h00, 8'h00, 14'h0000, "R2");

    // R5: arithmetic strobes and collisions
    step(1'b0, 16'h0000, 8'h0F, 8'h0A, 8'h00, 14'h0010, "R5");
    step(1'b0, 16'h0000, 8'hF0, 8'h50, 8'h00, 14'h0010, "R5");
    step(1'b1, fSet(0), 8'h03, 8'h02, 8'h00, 14'h0010, "R5");
    step(1'b1, fClr(1), 8'h06, 8'h06, 8'h00, 14'h0010, "R5");
    step(1'b1, fBst(3, 4), 8'h41, 8'h40, 8'h00, 14'h0010, "R5");
    step(1'b1, fBst(3, 4), 8'h41, 8'h00, 8'h10, 14'h0010, "R8");

    // R6 / R7: every flag, both polarities, varied offsets
    step(1'b0, 16'h0000, 8'hFF, 8'hA5, 8'h00, 14'h0000, "R6");
    for (int f = 0; f < 8; f++) begin
      step(1'b1, fBr(1'b0, f * 9 - 30, f), 8'h00, 8'h00, 8'h00, 14'h0200, "R6");
      step(1'b1, fBr(1'b1, f * 9 - 30, f), 8'h00, 8'h00, 8'h00, 14'h0200, "R6");
    end
    step(1'b1, fBr(1'b0, 63, 0), 8'h00, 8'h00, 8'h00, 14'h0040, "R7");
    step(1'b1, fBr(1'b0, -64, 0), 8'h00, 8'h00, 8'h00, 14'h0040, "R7");
    step(1'b1, fBr(1'b0, -64, 0), 8'h00, 8'h00, 8'h00, 14'h0010, "R7");
    step(1'b1, fBr(1'b0, 5, 2), 8'h00, 8'h00, 8'h00, 14'h3FFE, "R7");
    step(1'b1, fBr(1'b0, 0, 1), 8'h00, 8'h00, 8'h00, 14'h3FFF, "R7");
    step(1'b1, fSet(3), 8'h00, 8'h00, 8'h00, 14'h3FFF, "R7");

    // R8 / R9: bit transfers through T
    step(1'b1, fBst(17, 7), 8'h00, 8'h00, 8'h80, 14'h0001, "R8");
    step(1'b1, fBld(21, 2), 8'h00, 8'h00, 8'h00, 14'h0001, "R9");
    step(1'b1, fBst(17, 0), 8'h00, 8'h00, 8'hFE, 14'h0001, "R8");
    step(1'b1, fBld(31, 5), 8'h00, 8'h00, 8'hFF, 14'h0001, "R9");

    // R10: skip on clear and on set
    step(1'b1, fSkp(1'b0, 4, 3), 8'h00, 8'h00, 8'h08, 14'h0002, "R10");
    step(1'b1, fSkp(1'b0, 4, 3), 8'h00, 8'h00, 8'hF7, 14'h0002, "R10");
    step(1'b1, fSkp(1'b1, 9, 6), 8'h00, 8'h00, 8'h40, 14'h0002, "R10");
    step(1'b1, fSkp(1'b1, 9, 6), 8'h00, 8'h00, 8'hBF, 14'h0002, "R10");

    // R11: invalid cycles carry no effect from the instruction word
    step(1'b0, fSet(5), 8'h00, 8'h00, 8'h00, 14'h0123, "R11");
    step(1'b0, fBr(1'b1, 20, 5), 8'h00, 8'h00, 8'h00, 14'h0123, "R11");
    step(1'b0, fSkp(1'b0, 1, 1), 8'h00, 8'h00, 8'h00, 14'h0123, "R11");
    step(1'b0, fBld(2, 2), 8'h00, 8'h00, 8'h00, 14'h0123, "R11");
    step(1'b0, fBst(2, 2), 8'h00, 8'h00, 8'hFF, 14'h0123, "R11");

    // R1: reset in the middle of operation
    step(1'b1, fSet(4), 8'hFF, 8'hFF, 8'h00, 14'h0000, "R1");
    @(negedge clk);
    instrValid = 1'b0; aluFlagWe = '0;
    @(negedge clk);
    rstN = 1'b0;
    #1 checkVal("R1", "sreg after mid reset", 32'(sreg), 32'h0);
    mdlSreg = '0;
    @(negedge clk);
    rstN = 1'b1;
    step(1'b1, fBr(1'b1, 3, 7), 8'h00, 8'h00, 8'h00, 14'h0050, "R1");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule